// File: doc/BRIEF.md
# Message Arrival Notification Dispatcher

This block turns a "message complete" event from a network interface into a notification for one thread of a multithreaded core. The event carries a per-receiver descriptor: an index, a delivery method, the target hardware context, a lock address, and a program counter, stack pointer and notification-structure pointer for the handler. The dispatcher first waits until the notification structure in the receiver's memory has been written. It then delivers the arrival in one of three ways. It can release a waiting thread by clearing its entry in a hardware lock table. It can steer a running thread to a user-level handler. It can start a fresh thread in a hardware context.

When hardware cannot deliver the notification itself, the dispatcher sends a one-cycle request to the operating system instead. This happens when the target thread is not loaded, when no context can be obtained, when no matching lock is held, or when the method code is reserved. Threads place entries into the lock table through a separate set port. The dispatcher handles one event at a time, and it shows a busy flag to the network interface from acceptance until delivery is complete.

Top module: `notify_dispatch`

## Requirements
- R1: After reset, busy, wake_valid, redir_valid, spawn_valid, os_req and lock_full are low, and lock_held is all zeros.
- R2: An event is taken only when evt_valid is high while the block is idle. busy is high from the cycle after acceptance until delivery ends. Events offered while busy is high are ignored and produce no later output.
- R3: No delivery output (wake, redirect, spawn or OS request) appears until struct_done has been seen high after the event was accepted. While waiting, busy stays high.
- R4: The method field is decoded as 00 = lock release, 01 = branch, 10 = spawn, and 11 = reserved. A reserved method produces an OS request with reason 2. At most one of wake_valid, os_req, redir_valid and spawn_valid is high in any cycle.
- R5: A lock-mode event whose target context is loaded releases the lock. Loaded means its ctx_loaded bit is 1, and the table must hold an entry matching both the target context and the address. The block then clears every matching entry and pulses wake_valid for one cycle with wake_ctx equal to the target.
- R6: A lock-mode event whose target context is not loaded produces an OS request with reason 0 and leaves the lock table unchanged. A loaded target with no matching entry produces an OS request with reason 3.
- R7: A branch-mode event to a loaded context raises redir_valid with that context and the descriptor's pc and sp. These are held unchanged until core_ack, after which redir_valid and busy drop. A branch to a context that is not loaded produces an OS request with reason 0.
- R8: A spawn-mode event with at least one unloaded context raises spawn_valid with the lowest-numbered unloaded context, spawn_evict = 0, and the descriptor's pc, sp and notification pointer. These are held until core_ack.
- R9: A spawn-mode event with every context loaded uses evict_victim with spawn_evict = 1 when evict_allow is high. Otherwise it produces an OS request with reason 1.
- R10: os_req is a single-cycle pulse. While it is high, os_idx holds the accepted descriptor index and os_reason holds the 2-bit reason code.
- R11: A lock_set request writes an entry into a free slot of the table, and lock_held for that context rises. When all 16 entries are valid, lock_full is high and further set requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Message-complete event offered |
| evt_idx | input | IDX_W | Descriptor index |
| evt_method | input | 2 | Delivery method code |
| evt_ctx | input | CTX_W | Target hardware context |
| evt_addr | input | ADDR_W | Lock address for lock mode |
| evt_pc | input | PC_W | Handler program counter |
| evt_sp | input | PC_W | Handler stack pointer |
| evt_nptr | input | PC_W | Notification structure pointer |
| struct_done | input | 1 | Notification structure write finished |
| ctx_loaded | input | NCTX | Per-context: a thread is loaded |
| evict_allow | input | 1 | Policy: eviction permitted for spawn |
| evict_victim | input | CTX_W | Policy: context to evict |
| lock_set | input | 1 | Thread requests a lock entry |
| lock_set_ctx | input | CTX_W | Context of the lock entry |
| lock_set_addr | input | ADDR_W | Address of the lock entry |
| core_ack | input | 1 | Core accepted redirect or spawn |
| busy | output | 1 | Event in progress |
| wake_valid | output | 1 | One-cycle lock release pulse |
| wake_ctx | output | CTX_W | Context made runnable |
| redir_valid | output | 1 | Branch redirect request |
| redir_ctx | output | CTX_W | Context to redirect |
| redir_pc | output | PC_W | Handler program counter |
| redir_sp | output | PC_W | Handler stack pointer |
| spawn_valid | output | 1 | Thread start request |
| spawn_ctx | output | CTX_W | Context for the new thread |
| spawn_evict | output | 1 | Context is taken from a running thread |
| spawn_pc | output | PC_W | New thread program counter |
| spawn_sp | output | PC_W | New thread stack pointer |
| spawn_nptr | output | PC_W | New thread notification pointer |
| os_req | output | 1 | One-cycle OS fallback pulse |
| os_idx | output | IDX_W | Descriptor index for the OS |
| os_reason | output | 2 | 0 not loaded, 1 no context, 2 reserved method, 3 no lock |
| lock_held | output | NCTX | Per-context: lock table holds an entry |
| lock_full | output | 1 | All lock entries valid |

## Verification
The embedded properties check, on every cycle, several conditions that follow from the sequencing alone. No more than one delivery output is active at once. The OS request never lasts two cycles. Redirect and spawn payloads do not move until acknowledged. No delivery appears in the cycle right after acceptance. busy never drops except on a pulse or an acknowledge. A set request to a full table leaves the valid bits untouched. Other behaviour depends on choices that only the bench's scenarios can show: which method a given descriptor selects, which context a spawn receives, whether eviction is used, which reason code is reported, and whether a release frees exactly the matching lock entry.

// File: rtl/mnd_pkg.sv
package mnd_pkg;

  typedef enum logic [1:0] {
    M_LOCK   = 2'b00,
    M_BRANCH = 2'b01,
    M_SPAWN  = 2'b10,
    M_RSVD   = 2'b11
  } method_e;

  typedef enum logic [1:0] {
    RS_NOT_RES  = 2'd0,
    RS_NO_CTX   = 2'd1,
    RS_BAD_METH = 2'd2,
    RS_NO_LOCK  = 2'd3
  } reason_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_WR,
    ST_DISP,
    ST_WAIT_ACK
  } state_e;

endpackage

// File: rtl/mnd_lock_table.sv
module mnd_lock_table #(
  parameter int NLOCK  = 16,
  parameter int NCTX   = 4,
  parameter int ADDR_W = 32,
  localparam int CTX_W = $clog2(NCTX),
  localparam int LI_W  = $clog2(NLOCK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [CTX_W-1:0]  set_ctx,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              rel_en,
  input  logic [CTX_W-1:0]  rel_ctx,
  input  logic [ADDR_W-1:0] rel_addr,
  output logic              rel_hit,
  output logic              full,
  output logic [NCTX-1:0]   held
);

  logic [NLOCK-1:0]  vld_q, vld_d;
  logic [CTX_W-1:0]  ctx_q  [NLOCK];
  logic [ADDR_W-1:0] addr_q [NLOCK];
  logic [NLOCK-1:0]  hit_vec;
  logic [LI_W-1:0]   free_idx;
  logic              wr_en;

  genvar gi;
  generate
    for (gi = 0; gi < NLOCK; gi++) begin : g_match
      assign hit_vec[gi] = vld_q[gi] && (ctx_q[gi] == rel_ctx) && (addr_q[gi] == rel_addr);
    end
  endgenerate

  assign rel_hit = |hit_vec;
  assign full    = &vld_q;
  assign wr_en   = set_en && !full;

  always_comb begin
    free_idx = '0;
    for (int i = NLOCK - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = LI_W'(i);
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (rel_en) vld_d = vld_d & ~hit_vec;
    if (wr_en)  vld_d[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ctx_q[free_idx]  <= set_ctx;
      addr_q[free_idx] <= set_addr;
    end
  end

  genvar gc;
  generate
    for (gc = 0; gc < NCTX; gc++) begin : g_held
      logic [NLOCK-1:0] own;
      for (genvar ge = 0; ge < NLOCK; ge++) begin : g_ent
        assign own[ge] = vld_q[ge] && (ctx_q[ge] == CTX_W'(gc));
      end
      assign held[gc] = |own;
    end
  endgenerate

  // R11: a set request against a full table changes nothing
  a_r11_full_set_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && full && !rel_en) |=> $stable(vld_q));

  // R5: a release that matched leaves the matched entry free afterwards
  a_r5_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && rel_hit && !set_en) |=> ($countones(vld_q) < $countones($past(vld_q))));

endmodule

// File: rtl/mnd_ctx_alloc.sv
module mnd_ctx_alloc #(
  parameter int NCTX = 4,
  localparam int CTX_W = $clog2(NCTX)
) (
  input  logic [NCTX-1:0]  ctx_loaded,
  input  logic             evict_allow,
  input  logic [CTX_W-1:0] evict_victim,
  output logic             grant,
  output logic [CTX_W-1:0] grant_ctx,
  output logic             grant_evict
);

  logic             any_free;
  logic [CTX_W-1:0] free_ctx;

  always_comb begin
    free_ctx = '0;
    for (int i = NCTX - 1; i >= 0; i--) begin
      if (!ctx_loaded[i]) free_ctx = CTX_W'(i);
    end
  end

  assign any_free = !(&ctx_loaded);

  always_comb begin
    grant       = 1'b0;
    grant_ctx   = '0;
    grant_evict = 1'b0;
    if (any_free) begin
      grant     = 1'b1;
      grant_ctx = free_ctx;
    end else if (evict_allow) begin
      grant       = 1'b1;
      grant_ctx   = evict_victim;
      grant_evict = 1'b1;
    end
  end

endmodule

// File: rtl/mnd_ctrl.sv
module mnd_ctrl
  import mnd_pkg::*;
#(
  parameter int NCTX   = 4,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32,
  localparam int CTX_W = $clog2(NCTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [IDX_W-1:0]  evt_idx,
  input  logic [1:0]        evt_method,
  input  logic [CTX_W-1:0]  evt_ctx,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [PC_W-1:0]   evt_pc,
  input  logic [PC_W-1:0]   evt_sp,
  input  logic [PC_W-1:0]   evt_nptr,
  input  logic              struct_done,
  input  logic [NCTX-1:0]   ctx_loaded,
  input  logic              core_ack,
  input  logic              lock_hit,
  input  logic              alloc_grant,
  input  logic [CTX_W-1:0]  alloc_ctx,
  input  logic              alloc_evict,
  output logic              lk_rel_en,
  output logic [CTX_W-1:0]  lk_rel_ctx,
  output logic [ADDR_W-1:0] lk_rel_addr,
  output logic              busy,
  output logic              wake_valid,
  output logic [CTX_W-1:0]  wake_ctx,
  output logic              redir_valid,
  output logic [CTX_W-1:0]  redir_ctx,
  output logic [PC_W-1:0]   redir_pc,
  output logic [PC_W-1:0]   redir_sp,
  output logic              spawn_valid,
  output logic [CTX_W-1:0]  spawn_ctx,
  output logic              spawn_evict,
  output logic [PC_W-1:0]   spawn_pc,
  output logic [PC_W-1:0]   spawn_sp,
  output logic [PC_W-1:0]   spawn_nptr,
  output logic              os_req,
  output logic [IDX_W-1:0]  os_idx,
  output logic [1:0]        os_reason
);

  state_e            state_q, state_d;
  logic              capture;
  logic [IDX_W-1:0]  d_idx;
  method_e           d_meth;
  logic [CTX_W-1:0]  d_ctx;
  logic [ADDR_W-1:0] d_addr;
  logic [PC_W-1:0]   d_pc, d_sp, d_nptr;
  logic              tgt_res;

  logic              wake_q, wake_d;
  logic              os_q, os_d;
  reason_e           rsn_q, rsn_d;
  logic              redir_q, redir_d;
  logic              spawn_q, spawn_d;
  logic [CTX_W-1:0]  sp_ctx_q, sp_ctx_d;
  logic              sp_ev_q, sp_ev_d;

  assign tgt_res = ctx_loaded[d_ctx];

  // next-state and decision
  always_comb begin
    state_d   = state_q;
    capture   = 1'b0;
    wake_d    = 1'b0;
    os_d      = 1'b0;
    rsn_d     = rsn_q;
    redir_d   = redir_q;
    spawn_d   = spawn_q;
    sp_ctx_d  = sp_ctx_q;
    sp_ev_d   = sp_ev_q;
    lk_rel_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (evt_valid) begin
          capture = 1'b1;
          state_d = ST_WAIT_WR;
        end
      end
      ST_WAIT_WR: begin
        if (struct_done) state_d = ST_DISP;
      end
      ST_DISP: begin
        state_d = ST_IDLE;
        unique case (d_meth)
          M_LOCK: begin
            if (!tgt_res) begin
              os_d  = 1'b1;
              rsn_d = RS_NOT_RES;
            end else if (!lock_hit) begin
              os_d  = 1'b1;
              rsn_d = RS_NO_LOCK;
            end else begin
              lk_rel_en = 1'b1;
              wake_d    = 1'b1;
            end
          end
          M_BRANCH: begin
            if (!tgt_res) begin
              os_d  = 1'b1;
              rsn_d = RS_NOT_RES;
            end else begin
              redir_d = 1'b1;
              state_d = ST_WAIT_ACK;
            end
          end
          M_SPAWN: begin
            if (!alloc_grant) begin
              os_d  = 1'b1;
              rsn_d = RS_NO_CTX;
            end else begin
              spawn_d  = 1'b1;
              sp_ctx_d = alloc_ctx;
              sp_ev_d  = alloc_evict;
              state_d  = ST_WAIT_ACK;
            end
          end
          default: begin
            os_d  = 1'b1;
            rsn_d = RS_BAD_METH;
          end
        endcase
      end
      ST_WAIT_ACK: begin
        if (core_ack) begin
          redir_d = 1'b0;
          spawn_d = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      wake_q   <= 1'b0;
      os_q     <= 1'b0;
      rsn_q    <= RS_NOT_RES;
      redir_q  <= 1'b0;
      spawn_q  <= 1'b0;
      sp_ctx_q <= '0;
      sp_ev_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      wake_q   <= wake_d;
      os_q     <= os_d;
      rsn_q    <= rsn_d;
      redir_q  <= redir_d;
      spawn_q  <= spawn_d;
      sp_ctx_q <= sp_ctx_d;
      sp_ev_q  <= sp_ev_d;
    end
  end

  // descriptor latch, loaded only on acceptance
  always_ff @(posedge clk) begin
    if (capture) begin
      d_idx  <= evt_idx;
      d_meth <= method_e'(evt_method);
      d_ctx  <= evt_ctx;
      d_addr <= evt_addr;
      d_pc   <= evt_pc;
      d_sp   <= evt_sp;
      d_nptr <= evt_nptr;
    end
  end

  assign lk_rel_ctx  = d_ctx;
  assign lk_rel_addr = d_addr;
  assign busy        = (state_q != ST_IDLE);
  assign wake_valid  = wake_q;
  assign wake_ctx    = d_ctx;
  assign os_req      = os_q;
  assign os_idx      = d_idx;
  assign os_reason   = rsn_q;
  assign redir_valid = redir_q;
  assign redir_ctx   = d_ctx;
  assign redir_pc    = d_pc;
  assign redir_sp    = d_sp;
  assign spawn_valid = spawn_q;
  assign spawn_ctx   = sp_ctx_q;
  assign spawn_evict = sp_ev_q;
  assign spawn_pc    = d_pc;
  assign spawn_sp    = d_sp;
  assign spawn_nptr  = d_nptr;

  // R10: OS request lasts exactly one cycle
  a_r10_os_single: assert property (@(posedge clk) disable iff (!rst_n)
    os_req |=> !os_req);

  // R4: one delivery form at a time
  a_r4_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_valid, os_req, redir_valid, spawn_valid}));

  // R7: redirect held stable until acknowledged
  a_r7_redir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !core_ack) |=> (redir_valid && $stable(redir_pc) &&
                                    $stable(redir_sp) && $stable(redir_ctx)));

  // R8: spawn held stable until acknowledged
  a_r8_spawn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spawn_valid && !core_ack) |=> (spawn_valid && $stable(spawn_ctx) &&
                                    $stable(spawn_pc) && $stable(spawn_nptr)));

  // R3: nothing is delivered in the cycle right after acceptance
  a_r3_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> !(wake_valid || os_req || redir_valid || spawn_valid));

  // R2: busy ends only on a pulse or after an acknowledge
  a_r2_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (wake_valid || os_req || $past(core_ack)));

endmodule

// File: rtl/notify_dispatch.sv
module notify_dispatch #(
  parameter int NCTX   = 4,
  parameter int NLOCK  = 16,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32,
  localparam int CTX_W = $clog2(NCTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [IDX_W-1:0]  evt_idx,
  input  logic [1:0]        evt_method,
  input  logic [CTX_W-1:0]  evt_ctx,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [PC_W-1:0]   evt_pc,
  input  logic [PC_W-1:0]   evt_sp,
  input  logic [PC_W-1:0]   evt_nptr,
  input  logic              struct_done,
  input  logic [NCTX-1:0]   ctx_loaded,
  input  logic              evict_allow,
  input  logic [CTX_W-1:0]  evict_victim,
  input  logic              lock_set,
  input  logic [CTX_W-1:0]  lock_set_ctx,
  input  logic [ADDR_W-1:0] lock_set_addr,
  input  logic              core_ack,
  output logic              busy,
  output logic              wake_valid,
  output logic [CTX_W-1:0]  wake_ctx,
  output logic              redir_valid,
  output logic [CTX_W-1:0]  redir_ctx,
  output logic [PC_W-1:0]   redir_pc,
  output logic [PC_W-1:0]   redir_sp,
  output logic              spawn_valid,
  output logic [CTX_W-1:0]  spawn_ctx,
  output logic              spawn_evict,
  output logic [PC_W-1:0]   spawn_pc,
  output logic [PC_W-1:0]   spawn_sp,
  output logic [PC_W-1:0]   spawn_nptr,
  output logic              os_req,
  output logic [IDX_W-1:0]  os_idx,
  output logic [1:0]        os_reason,
  output logic [NCTX-1:0]   lock_held,
  output logic              lock_full
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              lk_rel_en, lk_hit;
  logic [CTX_W-1:0]  lk_rel_ctx;
  logic [ADDR_W-1:0] lk_rel_addr;
  logic              al_grant, al_evict;
  logic [CTX_W-1:0]  al_ctx;

  mnd_lock_table #(.NLOCK(NLOCK), .NCTX(NCTX), .ADDR_W(ADDR_W)) u_locks (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_en   (lock_set),
    .set_ctx  (lock_set_ctx),
    .set_addr (lock_set_addr),
    .rel_en   (lk_rel_en),
    .rel_ctx  (lk_rel_ctx),
    .rel_addr (lk_rel_addr),
    .rel_hit  (lk_hit),
    .full     (lock_full),
    .held     (lock_held)
  );

  mnd_ctx_alloc #(.NCTX(NCTX)) u_alloc (
    .ctx_loaded   (ctx_loaded),
    .evict_allow  (evict_allow),
    .evict_victim (evict_victim),
    .grant        (al_grant),
    .grant_ctx    (al_ctx),
    .grant_evict  (al_evict)
  );

  mnd_ctrl #(.NCTX(NCTX), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .PC_W(PC_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .evt_valid   (evt_valid),
    .evt_idx     (evt_idx),
    .evt_method  (evt_method),
    .evt_ctx     (evt_ctx),
    .evt_addr    (evt_addr),
    .evt_pc      (evt_pc),
    .evt_sp      (evt_sp),
    .evt_nptr    (evt_nptr),
    .struct_done (struct_done),
    .ctx_loaded  (ctx_loaded),
    .core_ack    (core_ack),
    .lock_hit    (lk_hit),
    .alloc_grant (al_grant),
    .alloc_ctx   (al_ctx),
    .alloc_evict (al_evict),
    .lk_rel_en   (lk_rel_en),
    .lk_rel_ctx  (lk_rel_ctx),
    .lk_rel_addr (lk_rel_addr),
    .busy        (busy),
    .wake_valid  (wake_valid),
    .wake_ctx    (wake_ctx),
    .redir_valid (redir_valid),
    .redir_ctx   (redir_ctx),
    .redir_pc    (redir_pc),
    .redir_sp    (redir_sp),
    .spawn_valid (spawn_valid),
    .spawn_ctx   (spawn_ctx),
    .spawn_evict (spawn_evict),
    .spawn_pc    (spawn_pc),
    .spawn_sp    (spawn_sp),
    .spawn_nptr  (spawn_nptr),
    .os_req      (os_req),
    .os_idx      (os_idx),
    .os_reason   (os_reason)
  );

endmodule

// File: tb/notify_dispatch_tb_top.sv
`timescale 1ns/1ps
module notify_dispatch_tb_top;

  localparam int NCTX = 4, IDX_W = 8, ADDR_W = 32, PC_W = 32, CTX_W = 2;
  localparam logic [1:0] K_WAKE = 2'd0, K_OS = 2'd1, K_REDIR = 2'd2, K_SPAWN = 2'd3;

  typedef struct packed {
    logic [1:0] meth;
    logic [1:0] tgt;
    logic [3:0] loaded;
    logic       allow;
    logic [1:0] victim;
    logic [1:0] kind;
    logic [1:0] ectx;
    logic       eev;
    logic [1:0] ersn;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 2'd1, 4'b0010, 1'b0, 2'd0, K_REDIR, 2'd1, 1'b0, 2'd0}, // R7 branch ok
    '{2'b01, 2'd2, 4'b0010, 1'b0, 2'd0, K_OS,    2'd0, 1'b0, 2'd0}, // R7 not loaded
    '{2'b10, 2'd0, 4'b0001, 1'b0, 2'd0, K_SPAWN, 2'd1, 1'b0, 2'd0}, // R8 lowest free
    '{2'b10, 2'd0, 4'b1011, 1'b0, 2'd0, K_SPAWN, 2'd2, 1'b0, 2'd0}, // R8
    '{2'b10, 2'd0, 4'b1111, 1'b1, 2'd3, K_SPAWN, 2'd3, 1'b1, 2'd0}, // R9 evict
    '{2'b10, 2'd0, 4'b1111, 1'b0, 2'd3, K_OS,    2'd0, 1'b0, 2'd1}, // R9 no ctx
    '{2'b11, 2'd0, 4'b1111, 1'b0, 2'd0, K_OS,    2'd0, 1'b0, 2'd2}, // R4 reserved
    '{2'b00, 2'd0, 4'b1110, 1'b0, 2'd0, K_OS,    2'd0, 1'b0, 2'd0}  // R6 not loaded
  };

  logic clk = 1'b0, rst_n;
  logic evt_valid, struct_done, evict_allow, lock_set, core_ack;
  logic [IDX_W-1:0] evt_idx;
  logic [1:0] evt_method;
  logic [CTX_W-1:0] evt_ctx, evict_victim, lock_set_ctx;
  logic [ADDR_W-1:0] evt_addr, lock_set_addr;
  logic [PC_W-1:0] evt_pc, evt_sp, evt_nptr;
  logic [NCTX-1:0] ctx_loaded;
  logic busy, wake_valid, redir_valid, spawn_valid, spawn_evict, os_req, lock_full;
  logic [CTX_W-1:0] wake_ctx, redir_ctx, spawn_ctx;
  logic [PC_W-1:0] redir_pc, redir_sp, spawn_pc, spawn_sp, spawn_nptr;
  logic [IDX_W-1:0] os_idx;
  logic [1:0] os_reason;
  logic [NCTX-1:0] lock_held;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  notify_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_idx(evt_idx),
    .evt_method(evt_method), .evt_ctx(evt_ctx), .evt_addr(evt_addr),
    .evt_pc(evt_pc), .evt_sp(evt_sp), .evt_nptr(evt_nptr),
    .struct_done(struct_done), .ctx_loaded(ctx_loaded), .evict_allow(evict_allow),
    .evict_victim(evict_victim), .lock_set(lock_set), .lock_set_ctx(lock_set_ctx),
    .lock_set_addr(lock_set_addr), .core_ack(core_ack), .busy(busy),
    .wake_valid(wake_valid), .wake_ctx(wake_ctx), .redir_valid(redir_valid),
    .redir_ctx(redir_ctx), .redir_pc(redir_pc), .redir_sp(redir_sp),
    .spawn_valid(spawn_valid), .spawn_ctx(spawn_ctx), .spawn_evict(spawn_evict),
    .spawn_pc(spawn_pc), .spawn_sp(spawn_sp), .spawn_nptr(spawn_nptr),
    .os_req(os_req), .os_idx(os_idx), .os_reason(os_reason),
    .lock_held(lock_held), .lock_full(lock_full)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic offer(input logic [IDX_W-1:0] idx, input logic [1:0] m,
                       input logic [CTX_W-1:0] c, input logic [ADDR_W-1:0] a,
                       input logic [PC_W-1:0] pc);
    @(negedge clk);
    evt_valid = 1'b1; evt_idx = idx; evt_method = m; evt_ctx = c; evt_addr = a;
    evt_pc = pc; evt_sp = pc + 32'h100; evt_nptr = pc + 32'h200;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  // done pulse, then sample the registered delivery outputs
  task automatic finish_write;
    struct_done = 1'b1;
    @(negedge clk);
    struct_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_lock(input logic [CTX_W-1:0] c, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    lock_set = 1'b1; lock_set_ctx = c; lock_set_addr = a;
    @(negedge clk);
    lock_set = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_valid = 0; struct_done = 0; evict_allow = 0; lock_set = 0;
    core_ack = 0; evt_idx = 0; evt_method = 0; evt_ctx = 0; evt_addr = 0;
    evt_pc = 0; evt_sp = 0; evt_nptr = 0; ctx_loaded = 0; evict_victim = 0;
    lock_set_ctx = 0; lock_set_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 outputs", {wake_valid, redir_valid, spawn_valid, os_req, lock_full}, 0);
    chk("R1 lock_held", lock_held, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      ctx_loaded = VECS[i].loaded; evict_allow = VECS[i].allow;
      evict_victim = VECS[i].victim;
      offer(8'(i + 16), VECS[i].meth, VECS[i].tgt, 32'h0, 32'h1000 + 32'(i * 16));
      chk("R2 busy after accept", busy, 1);
      finish_write();
      case (VECS[i].kind)
        K_OS: begin
          chk("R10 os pulse", os_req, 1);
          chk("R10 os idx", os_idx, i + 16);
          chk("R6 R7 R9 R4 os reason", os_reason, VECS[i].ersn);
          @(negedge clk);
          chk("R10 os single cycle", {os_req, busy}, 0);
        end
        K_REDIR: begin
          chk("R7 redir", {redir_valid, redir_ctx}, {1'b1, VECS[i].ectx});
          chk("R7 redir pc/sp", {redir_pc, redir_sp},
              {32'h1000 + 32'(i * 16), 32'h1100 + 32'(i * 16)});
          @(negedge clk);
          chk("R7 held", {redir_valid, busy}, 2'b11);
          core_ack = 1'b1; @(negedge clk); core_ack = 1'b0;
          chk("R7 released", {redir_valid, busy}, 0);
        end
        default: begin
          chk("R8 R9 spawn", {spawn_valid, spawn_ctx, spawn_evict},
              {1'b1, VECS[i].ectx, VECS[i].eev});
          chk("R8 spawn nptr", {spawn_pc, spawn_nptr},
              {32'h1000 + 32'(i * 16), 32'h1200 + 32'(i * 16)});
          @(negedge clk);
          chk("R8 held", {spawn_valid, busy}, 2'b11);
          core_ack = 1'b1; @(negedge clk); core_ack = 1'b0;
          chk("R8 released", {spawn_valid, busy}, 0);
        end
      endcase
    end

    // R3 waits for structure write; R2 ignores events while busy
    ctx_loaded = 4'b1111;
    offer(8'h05, 2'b11, 2'd0, 32'h0, 32'h0);
    offer(8'h09, 2'b01, 2'd1, 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    chk("R3 no output before struct_done", {os_req, redir_valid, busy}, 3'b001);
    finish_write();
    chk("R2 first event kept", {os_req, os_idx, os_reason}, {1'b1, 8'h05, 2'd2});
    repeat (4) @(negedge clk);
    chk("R2 busy event ignored", {os_req, redir_valid, busy}, 0);

    // R11 set and R5 release
    set_lock(2'd1, 32'hA0);
    chk("R11 lock_held", lock_held, 4'b0010);
    ctx_loaded = 4'b0010;
    offer(8'h21, 2'b00, 2'd1, 32'hB0, 32'h0);
    finish_write();
    chk("R6 no lock match", {os_req, os_reason}, {1'b1, 2'd3});
    chk("R6 table kept", lock_held, 4'b0010);
    offer(8'h22, 2'b00, 2'd1, 32'hA0, 32'h0);
    finish_write();
    chk("R5 wake", {wake_valid, wake_ctx, os_req}, {1'b1, 2'd1, 1'b0});
    @(negedge clk);
    chk("R5 wake pulse ends, lock cleared", {wake_valid, lock_held}, 0);

    // R6 not loaded leaves table unchanged
    set_lock(2'd0, 32'hC0);
    ctx_loaded = 4'b1110;
    offer(8'h23, 2'b00, 2'd0, 32'hC0, 32'h0);
    finish_write();
    chk("R6 not loaded", {os_req, os_reason}, {1'b1, 2'd0});
    @(negedge clk);
    chk("R6 lock kept", lock_held, 4'b0001);

    // R11 full table
    for (int k = 0; k < 15; k++) set_lock(2'd2, 32'(k));
    chk("R11 full", lock_full, 1);
    set_lock(2'd3, 32'hD0);
    chk("R11 set ignored when full", lock_held, 4'b0101);
    ctx_loaded = 4'b0100;
    offer(8'h24, 2'b00, 2'd2, 32'd3, 32'h0);
    finish_write();
    chk("R5 release from full table", {wake_valid, wake_ctx}, {1'b1, 2'd2});
    @(negedge clk);
    chk("R11 full drops after release", lock_full, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule